// File: doc/BRIEF.md
# Character display bus bridge

This block sits between a simple system-bus slave port and a text-mode video generator. The generator owns three memories: a character code map, a colour map and a glyph table. Two address bits pick which of the three memories a request goes to. The bridge gates the write enable and a read strobe towards that memory only. It passes the remaining address bits, the write data and the byte enables to all three memories unchanged.

Each attached memory already registers its read output. For that reason the bridge adds no register on the return path. It registers only the memory choice it made in the request cycle. On the next cycle it uses that stored choice to steer the arriving memory data onto the bus with pure combinational logic. Read data therefore reaches the bus exactly one clock after the read request.

Top module: `chardisp_bus_bridge`

## Requirements
- R1: When address bits [13:12] are 2'b00, the character code map is the target. A write reaches it through `cmap_we`, a read raises `cmap_re`, and one clock after a read `bus_rdata` equals `cmap_rdata`.
- R2: When address bits [13:12] are 2'b01, the colour map is the target. This works through `clr_we`, `clr_re` and `clr_rdata`, in the same way as R1.
- R3: When address bits [13:12] are 2'b10, the glyph table is the target. This works through `gly_we`, `gly_re` and `gly_rdata`, in the same way as R1.
- R4: A write enable towards a memory is high only when `bus_valid` and `bus_we` are both high and that memory is the decoded target. At most one write enable is high in any cycle.
- R5: Read data reaches `bus_rdata` one clock after the request, with no extra register stage. Data written earlier can be read back through the same memory.
- R6: The address bits below bit 12, `bus_wdata` and `bus_be` appear unchanged on the address, data and byte-enable outputs of all three memories in every cycle.
- R7: A read strobe is high only for the decoded target memory, and only when `bus_valid` is high and `bus_we` is low.
- R8: Address bits [13:12] equal to 2'b11 select no memory. Writes to that range raise no write enable. Reads of it return zero one clock later.
- R9: If the previous cycle held no valid read (the bus was idle or performed a write), `bus_rdata` is zero.
- R10: While reset is active, and in the first cycle after it, `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (14) | Request address; bits [13:12] pick the memory |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_be | input | DATA_W/8 (4) | Byte enables |
| bus_rdata | output | DATA_W (32) | Read data, one clock after the request |
| cmap_we | output | 1 | Character map write enable |
| cmap_re | output | 1 | Character map read strobe |
| cmap_addr | output | SEL_LSB (12) | Character map address |
| cmap_wdata | output | DATA_W (32) | Character map write data |
| cmap_be | output | DATA_W/8 (4) | Character map byte enables |
| cmap_rdata | input | DATA_W (32) | Character map registered read data |
| clr_we | output | 1 | Colour map write enable |
| clr_re | output | 1 | Colour map read strobe |
| clr_addr | output | SEL_LSB (12) | Colour map address |
| clr_wdata | output | DATA_W (32) | Colour map write data |
| clr_be | output | DATA_W/8 (4) | Colour map byte enables |
| clr_rdata | input | DATA_W (32) | Colour map registered read data |
| gly_we | output | 1 | Glyph table write enable |
| gly_re | output | 1 | Glyph table read strobe |
| gly_addr | output | SEL_LSB (12) | Glyph table address |
| gly_wdata | output | DATA_W (32) | Glyph table write data |
| gly_be | output | DATA_W/8 (4) | Glyph table byte enables |
| gly_rdata | input | DATA_W (32) | Glyph table registered read data |

## Verification
The bench uses the default parameters: a 14-bit address with the select field at bit 12, and 32-bit data with four byte enables. With those values each modelled memory is 4096 words deep. Random addresses therefore hit all four select codes, including the unused 2'b11 range, and partial byte-enable writes land in words that are later read back. Back-to-back reads that switch memory on every cycle exercise the one-cycle alignment between the stored choice and the arriving data.

// File: rtl/chardisp_bridge_pkg.sv
package chardisp_bridge_pkg;
   localparam int unsigned TGT_COUNT = 3;
   localparam int unsigned TGT_SEL_W = 2;

   typedef enum logic [TGT_SEL_W-1:0] {
      TGT_CHAR  = 2'b00,
      TGT_COLOR = 2'b01,
      TGT_GLYPH = 2'b10,
      TGT_NONE  = 2'b11
   } tgt_sel_e;
endpackage

// File: rtl/chardisp_tgt_decode.sv
module chardisp_tgt_decode
   import chardisp_bridge_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 valid,
   input  logic                 we,
   input  tgt_sel_e             sel,
   output logic [TGT_COUNT-1:0] we_vec,
   output logic [TGT_COUNT-1:0] re_vec
);
   for (genvar t = 0; t < TGT_COUNT; t++) begin : g_tgt
      logic hit;
      assign hit       = (sel == tgt_sel_e'(t));
      assign we_vec[t] = valid & we & hit;
      assign re_vec[t] = valid & ~we & hit;
   end

   AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({we_vec, re_vec}));                                     // R4
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> (we_vec == '0 && re_vec == '0));                       // R7
   AST_NONE_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && sel == TGT_NONE) |-> (we_vec == '0));                   // R8
endmodule

// File: rtl/chardisp_sel_track.sv
module chardisp_sel_track
   import chardisp_bridge_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     rd_req,
   input  tgt_sel_e sel,
   output tgt_sel_e sel_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= TGT_NONE;
      else        sel_q <= rd_req ? sel : TGT_NONE;
   end

   AST_SEL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> (sel_q == TGT_NONE));                                 // R9
endmodule

// File: rtl/chardisp_rdata_mux.sv
module chardisp_rdata_mux
   import chardisp_bridge_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  tgt_sel_e                          sel_q,
   input  logic [TGT_COUNT-1:0][DATA_W-1:0]  mem_rdata,
   output logic [DATA_W-1:0]                 rdata
);
   logic [TGT_COUNT-1:0][DATA_W-1:0] masked;

   for (genvar t = 0; t < TGT_COUNT; t++) begin : g_mask
      assign masked[t] = (sel_q == tgt_sel_e'(t)) ? mem_rdata[t] : '0;
   end

   always_comb begin
      rdata = '0;
      for (int t = 0; t < TGT_COUNT; t++) rdata |= masked[t];
   end
endmodule

// File: rtl/chardisp_bus_bridge.sv
module chardisp_bus_bridge
   import chardisp_bridge_pkg::*;
#(
   parameter int unsigned ADDR_W  = 14,
   parameter int unsigned SEL_LSB = 12,
   parameter int unsigned DATA_W  = 32,
   localparam int unsigned BE_W   = DATA_W / 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_valid,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   input  logic [BE_W-1:0]    bus_be,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               cmap_we,
   output logic               cmap_re,
   output logic [SEL_LSB-1:0] cmap_addr,
   output logic [DATA_W-1:0]  cmap_wdata,
   output logic [BE_W-1:0]    cmap_be,
   input  logic [DATA_W-1:0]  cmap_rdata,
   output logic               clr_we,
   output logic               clr_re,
   output logic [SEL_LSB-1:0] clr_addr,
   output logic [DATA_W-1:0]  clr_wdata,
   output logic [BE_W-1:0]    clr_be,
   input  logic [DATA_W-1:0]  clr_rdata,
   output logic               gly_we,
   output logic               gly_re,
   output logic [SEL_LSB-1:0] gly_addr,
   output logic [DATA_W-1:0]  gly_wdata,
   output logic [BE_W-1:0]    gly_be,
   input  logic [DATA_W-1:0]  gly_rdata
);
   if (SEL_LSB + TGT_SEL_W > ADDR_W) begin : g_bad_addr
      $error("select field does not fit in the address");
   end
   if (DATA_W % 8 != 0 || DATA_W == 0) begin : g_bad_data
      $error("data width must be a non-zero multiple of 8");
   end

   tgt_sel_e               sel, sel_q;
   logic [TGT_COUNT-1:0]   we_vec, re_vec;
   logic                   rd_req;
   logic [SEL_LSB-1:0]     low_addr;
   logic [TGT_COUNT-1:0][DATA_W-1:0] mem_rdata;

   assign sel      = tgt_sel_e'(bus_addr[SEL_LSB +: TGT_SEL_W]);
   assign low_addr = bus_addr[SEL_LSB-1:0];
   assign rd_req   = bus_valid & ~bus_we;

   chardisp_tgt_decode u_decode (
      .clk    (clk),
      .rst_n  (rst_n),
      .valid  (bus_valid),
      .we     (bus_we),
      .sel    (sel),
      .we_vec (we_vec),
      .re_vec (re_vec)
   );

   chardisp_sel_track u_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_req (rd_req),
      .sel    (sel),
      .sel_q  (sel_q)
   );

   assign mem_rdata[TGT_CHAR]  = cmap_rdata;
   assign mem_rdata[TGT_COLOR] = clr_rdata;
   assign mem_rdata[TGT_GLYPH] = gly_rdata;

   chardisp_rdata_mux #(.DATA_W(DATA_W)) u_mux (
      .sel_q     (sel_q),
      .mem_rdata (mem_rdata),
      .rdata     (bus_rdata)
   );

   assign cmap_we = we_vec[TGT_CHAR];
   assign clr_we  = we_vec[TGT_COLOR];
   assign gly_we  = we_vec[TGT_GLYPH];
   assign cmap_re = re_vec[TGT_CHAR];
   assign clr_re  = re_vec[TGT_COLOR];
   assign gly_re  = re_vec[TGT_GLYPH];

   assign cmap_addr  = low_addr;
   assign clr_addr   = low_addr;
   assign gly_addr   = low_addr;
   assign cmap_wdata = bus_wdata;
   assign clr_wdata  = bus_wdata;
   assign gly_wdata  = bus_wdata;
   assign cmap_be    = bus_be;
   assign clr_be     = bus_be;
   assign gly_be     = bus_be;

   AST_CHAR_RD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && sel == TGT_CHAR) |=> (bus_rdata == cmap_rdata));       // R1
   AST_COLOR_RD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && sel == TGT_COLOR) |=> (bus_rdata == clr_rdata));       // R2
   AST_GLYPH_RD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && sel == TGT_GLYPH) |=> (bus_rdata == gly_rdata));       // R3
   AST_NONE_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && sel == TGT_NONE) |=> (bus_rdata == '0));               // R8
   AST_NO_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> (bus_rdata == '0));                                   // R9
   AST_PASS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (cmap_addr == bus_addr[SEL_LSB-1:0]) && (gly_be == bus_be));      // R6
endmodule

// File: tb/chardisp_bus_bridge_tb.sv
`timescale 1ns/1ps
module chardisp_bus_bridge_tb;
   localparam int AW = 14, LSB = 12, DW = 32, BW = 4, DEPTH = 4096;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_valid = 0, bus_we = 0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [BW-1:0] bus_be = '0;
   logic [DW-1:0] bus_rdata;
   logic cmap_we, cmap_re, clr_we, clr_re, gly_we, gly_re;
   logic [LSB-1:0] cmap_addr, clr_addr, gly_addr;
   logic [DW-1:0] cmap_wdata, clr_wdata, gly_wdata;
   logic [BW-1:0] cmap_be, clr_be, gly_be;
   logic [DW-1:0] rd_q [3];

   always #2.5 clk = ~clk;

   chardisp_bus_bridge u_dut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
      .cmap_we(cmap_we), .cmap_re(cmap_re), .cmap_addr(cmap_addr), .cmap_wdata(cmap_wdata),
      .cmap_be(cmap_be), .cmap_rdata(rd_q[0]),
      .clr_we(clr_we), .clr_re(clr_re), .clr_addr(clr_addr), .clr_wdata(clr_wdata),
      .clr_be(clr_be), .clr_rdata(rd_q[1]),
      .gly_we(gly_we), .gly_re(gly_re), .gly_addr(gly_addr), .gly_wdata(gly_wdata),
      .gly_be(gly_be), .gly_rdata(rd_q[2])
   );

   logic [2:0] we_o, re_o;
   logic [LSB-1:0] addr_o [3];
   logic [DW-1:0] wdata_o [3];
   logic [BW-1:0] be_o [3];
   assign we_o = {gly_we, clr_we, cmap_we};
   assign re_o = {gly_re, clr_re, cmap_re};
   assign addr_o[0] = cmap_addr;  assign addr_o[1] = clr_addr;  assign addr_o[2] = gly_addr;
   assign wdata_o[0] = cmap_wdata; assign wdata_o[1] = clr_wdata; assign wdata_o[2] = gly_wdata;
   assign be_o[0] = cmap_be;  assign be_o[1] = clr_be;  assign be_o[2] = gly_be;

   logic [DW-1:0] mem [3][DEPTH];
   logic [DW-1:0] exp_rd;
   int exp_tag;  // 0..2 memory, 3 none range, 4 no read
   int checks = 0, failures = 0;
   bit done = 0, run = 0;
   string tags [5] = '{"R1", "R2", "R3", "R8", "R9"};
   string mtags [3] = '{"R1", "R2", "R3"};

   initial begin
      for (int t = 0; t < 3; t++) begin
         rd_q[t] = '0;
         for (int i = 0; i < DEPTH; i++) mem[t][i] = {t[3:0], 4'h5, i[11:0], ~i[11:0]};
      end
   end

   // memory models and behavioural read expectation
   always @(posedge clk) begin
      int s;
      s = int'(bus_addr[13:12]);
      if (!rst_n) begin
         exp_rd <= '0; exp_tag <= 4;
      end else if (bus_valid && !bus_we) begin
         exp_rd  <= (s < 3) ? mem[s][bus_addr[LSB-1:0]] : '0;
         exp_tag <= s;
      end else begin
         exp_rd <= '0; exp_tag <= 4;
      end
      for (int t = 0; t < 3; t++) begin
         if (re_o[t]) rd_q[t] <= mem[t][addr_o[t]];
         if (we_o[t])
            for (int b = 0; b < BW; b++)
               if (be_o[t][b]) mem[t][addr_o[t]][8*b +: 8] <= wdata_o[t][8*b +: 8];
      end
   end

   task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (run && rst_n) begin
         int s;
         s = int'(bus_addr[13:12]);
         for (int t = 0; t < 3; t++) begin
            chk((s == 3) ? "R8" : "R4", DW'(we_o[t]), DW'(bus_valid && bus_we && s == t));
            chk("R7", DW'(re_o[t]), DW'(bus_valid && !bus_we && s == t));
            chk("R6", DW'(addr_o[t]), DW'(bus_addr[LSB-1:0]));
            chk("R6", wdata_o[t], bus_wdata);
            chk("R6", DW'(be_o[t]), DW'(bus_be));
         end
         chk(tags[exp_tag], bus_rdata, exp_rd);
         if (exp_tag < 3) chk("R5", bus_rdata, exp_rd);
      end
   end

   task automatic drive(bit v, bit w, logic [1:0] s, logic [LSB-1:0] a,
                        logic [DW-1:0] d, logic [BW-1:0] be);
      @(posedge clk); #1;
      bus_valid = v; bus_we = w; bus_addr = {s, a}; bus_wdata = d; bus_be = be;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10", bus_rdata, '0);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R10", bus_rdata, '0);
      run = 1;
      // writes to each memory with varied byte enables (R1, R2, R3, R5)
      drive(1, 1, 2'b00, 12'd5, 32'hA5A5_0001, 4'b1111);
      drive(1, 1, 2'b01, 12'd5, 32'h1234_5678, 4'b0011);
      drive(1, 1, 2'b10, 12'd5, 32'hDEAD_BEEF, 4'b1000);
      drive(1, 1, 2'b11, 12'd5, 32'hFFFF_FFFF, 4'b1111);   // R8: ignored
      drive(1, 0, 2'b00, 12'd5, '0, '0);
      drive(1, 0, 2'b01, 12'd5, '0, '0);
      drive(1, 0, 2'b10, 12'd5, '0, '0);
      drive(1, 0, 2'b11, 12'd5, '0, '0);                   // R8: zero
      drive(0, 0, 2'b00, 12'd5, '0, '0);                   // R9: idle
      drive(1, 1, 2'b00, 12'd7, 32'h0BAD_F00D, 4'b0101);   // R9: write
      drive(1, 0, 2'b00, 12'd7, '0, '0);
      // back-to-back reads switching memory every cycle
      for (int i = 0; i < 24; i++) drive(1, 0, 2'(i % 4), 12'(i * 37), '0, '0);
      drive(0, 0, 2'b00, '0, '0, '0);
      // random traffic
      for (int i = 0; i < 600; i++)
         drive(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
               2'($urandom_range(0, 3)), 12'($urandom_range(0, 15)),
               $urandom, 4'($urandom_range(0, 15)));
      drive(0, 0, 2'b00, '0, '0, '0);
      @(negedge clk);
      @(negedge clk);
      run = 0;
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule